// File: doc/BRIEF.md
# Flow-Selecting Packet Thinner with Snap Truncation and Full-Packet Digest

This block sits on a capture path between a receive port and a host queue and thins traffic so that the host sees only the flows it cares about. Each arriving Ethernet frame is parsed on the fly. The block pulls out the IPv4 protocol number, the two IPv4 addresses and, for TCP and UDP, the two layer-4 port numbers. The resulting key is compared in parallel against a small bank of rules that software programs. Every rule holds a value and a compare mask for each field. A frame that no enabled rule accepts produces no output at all.

An accepted frame is cut to a programmable snap length. After its last kept byte come four more bytes that carry a CRC-32 digest. The digest is computed over every byte of the original frame, including the bytes that were cut off. Because the digest is known only when the frame ends, the kept bytes wait in a small buffer that uses a commit pointer. Bytes that arrive before the accept/drop decision are held uncommitted. A drop rolls them back, so no byte of a rejected frame ever leaves the block.

The stream is byte-wide and has no backpressure. The input is never stalled, so the block keeps up with minimum-size frames arriving back to back. Software reaches the snap length, the rules and three event counters through a simple word-addressed register port.

Top module: `ft_snap_filter`

## Requirements
- R1: A frame is forwarded when at least one enabled rule matches. A rule matches when every key bit with a 1 in that rule's mask equals the rule's value bit. Rule r occupies register words 16+8r to 16+8r+7:
  - word 0: source address value; word 1: source address mask.
  - word 2: destination address value; word 3: destination address mask.
  - word 4: {source port, destination port} values; word 5: the matching masks, in the same halves.
  - word 6: {protocol mask[15:8], protocol value[7:0]}.
  - word 7 bit 0: enable.
- R2: A frame that no enabled rule matches produces no output beat at all.
- R3: A rule with its enable bit clear never matches, even with all masks zero. Any single enabled matching rule is enough to forward a frame.
- R4: A forwarded frame keeps only its first N bytes, where N is the snap length at register 0 (reset value 64). A frame of N bytes or fewer is forwarded whole.
- R5: Four digest bytes follow the kept bytes, least significant byte first. The digest is the reflected CRC-32 (polynomial 0x04C11DB7, initial value and final XOR all ones) over every input byte of the frame. tlast is high only on the final digest byte.
- R6: For a frame whose ethertype (bytes 12-13, big-endian) is not 0x0800, the protocol, address and port fields of the key are zero. For an IPv4 frame whose protocol is not 6 or 17, the port fields are zero.
- R7: For IPv4 frames the fields are read in network byte order:
  - header length: low nibble of byte 14 (values below 5 are treated as 5);
  - protocol: byte 23;
  - source address: bytes 26-29;
  - destination address: bytes 30-33;
  - source port, then destination port: the four bytes starting at byte 14 + 4 × header length.
- R8: Register 1 counts forwarded frames, register 2 counts dropped frames, and register 3 counts forwarded frames longer than the snap length.
- R9: After reset there is no output, all counters read zero, all rules are disabled, and the snap length reads 64.
- R10: The input accepts one byte per cycle and is never stalled. Frames separated by four idle cycles are all forwarded, complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_axis_tvalid | input | 1 | Input byte valid |
| s_axis_tdata | input | 8 | Input frame byte |
| s_axis_tlast | input | 1 | Last byte of the input frame |
| m_axis_tvalid | output | 1 | Output byte valid |
| m_axis_tdata | output | 8 | Output byte (kept data or digest) |
| m_axis_tlast | output | 1 | Final digest byte of a forwarded frame |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |

## Verification
The assertions take the input for granted in two ways. First, after a frame's last byte there must be at least four idle cycles before the next frame starts, because that is when the digest bytes enter the buffer. Second, the sink must take every output byte as it appears. The checker states the gap rule as a property, and it also checks that the buffer never fills, which holds only when both conditions are met. The stimulus sends every frame as an unbroken run of bytes. It always leaves four or more idle cycles after tlast, and it never models a sink that holds off.

// File: rtl/ft_pkg.sv
// Shared types, register map and digest step for the flow thinner.
// Assumes byte-serial frames in network byte order.
package ft_pkg;

    typedef struct packed {
        logic [7:0]  proto;
        logic [31:0] sip;
        logic [31:0] dip;
        logic [15:0] sport;
        logic [15:0] dport;
    } ft_key_t;

    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_TCP  = 8'd6;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;

    localparam int REG_SNAP     = 0;
    localparam int REG_CNT_HIT  = 1;
    localparam int REG_CNT_DROP = 2;
    localparam int REG_CNT_CUT  = 3;
    localparam int RULE_BASE    = 16;
    localparam int RULE_WORDS   = 8;

    // Advance a reflected CRC-32 register by one byte.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ft_hdr_parse.sv
// Header field extractor. It tracks the byte index within a frame and
// builds the flow key one byte at a time. key_o already includes the
// current byte. key_end_o flags the byte that completes the key, or the
// frame's last byte if that comes first.
// Assumes each frame arrives as one unbroken run of bytes.
module ft_hdr_parse
    import ft_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic [LEN_W-1:0] idx_o,
    output ft_key_t          key_o,
    output logic             key_end_o
);

    logic [LEN_W-1:0] idx_q;
    logic [15:0] et_q, et_n;
    logic [3:0]  ihl_q, ihl_n;
    logic [7:0]  pr_q, pr_n;
    logic [31:0] sip_q, sip_n, dip_q, dip_n;
    logic [15:0] sp_q, sp_n, dp_q, dp_n;
    logic [3:0]  ihl_eff;
    logic [LEN_W-1:0] l4_off;
    logic        is_ip4, is_l4;

    assign ihl_eff = (ihl_q < 4'd5) ? 4'd5 : ihl_q;
    assign l4_off  = LEN_W'(14) + LEN_W'({ihl_eff, 2'b00});

    // Next value of each field register, folding in the current byte.
    always_comb begin
        et_n  = et_q;  ihl_n = ihl_q; pr_n = pr_q;
        sip_n = sip_q; dip_n = dip_q; sp_n = sp_q; dp_n = dp_q;
        if (in_valid) begin
            if (idx_q == LEN_W'(12) || idx_q == LEN_W'(13)) et_n = {et_q[7:0], in_data};
            if (idx_q == LEN_W'(14)) ihl_n = in_data[3:0];
            if (idx_q == LEN_W'(23)) pr_n = in_data;
            if (idx_q >= LEN_W'(26) && idx_q <= LEN_W'(29)) sip_n = {sip_q[23:0], in_data};
            if (idx_q >= LEN_W'(30) && idx_q <= LEN_W'(33)) dip_n = {dip_q[23:0], in_data};
            if (idx_q == l4_off || idx_q == l4_off + LEN_W'(1)) sp_n = {sp_q[7:0], in_data};
            if (idx_q == l4_off + LEN_W'(2) || idx_q == l4_off + LEN_W'(3)) dp_n = {dp_q[7:0], in_data};
        end
    end

    assign is_ip4 = (et_n == ETYPE_IPV4);
    assign is_l4  = is_ip4 && (pr_n == PROTO_TCP || pr_n == PROTO_UDP);

    // Present the key with fields zeroed where the frame type lacks them.
    always_comb begin
        key_o.proto = is_ip4 ? pr_n  : 8'h0;
        key_o.sip   = is_ip4 ? sip_n : 32'h0;
        key_o.dip   = is_ip4 ? dip_n : 32'h0;
        key_o.sport = is_l4  ? sp_n  : 16'h0;
        key_o.dport = is_l4  ? dp_n  : 16'h0;
    end

    assign key_end_o = in_valid && (in_last ||
                       (idx_q == LEN_W'(13) && !is_ip4) ||
                       (is_ip4 && idx_q == l4_off + LEN_W'(3)));
    assign idx_o = idx_q;

    // Hold field state; clear it at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || (in_valid && in_last)) begin
            idx_q <= '0; et_q <= '0; ihl_q <= '0; pr_q <= '0;
            sip_q <= '0; dip_q <= '0; sp_q <= '0; dp_q <= '0;
        end else if (in_valid) begin
            if (idx_q != '1) idx_q <= idx_q + LEN_W'(1);
            et_q <= et_n; ihl_q <= ihl_n; pr_q <= pr_n;
            sip_q <= sip_n; dip_q <= dip_n; sp_q <= sp_n; dp_q <= dp_n;
        end
    end

endmodule

// File: rtl/ft_rule_bank.sv
// Bank of masked flow rules, all compared in parallel against the key.
// A rule with its enable bit clear never hits. Reset disables every rule.
// Assumes register words are laid out as in ft_pkg (eight per rule).
module ft_rule_bank
    import ft_pkg::*;
#(
    parameter int NUM_RULES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  ft_key_t           key,
    output logic              hit
);

    logic [NUM_RULES-1:0] hit_vec;

    for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(RULE_BASE + r * RULE_WORDS);
        logic [31:0] sip_v, sip_m, dip_v, dip_m;
        logic [15:0] sp_v, sp_m, dp_v, dp_m;
        logic [7:0]  pr_v, pr_m;
        logic        en;
        logic        sel;

        assign sel = cfg_we && (cfg_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);

        // Register writes for this rule's eight words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sip_v <= '0; sip_m <= '0; dip_v <= '0; dip_m <= '0;
                sp_v <= '0; sp_m <= '0; dp_v <= '0; dp_m <= '0;
                pr_v <= '0; pr_m <= '0; en <= 1'b0;
            end else if (sel) begin
                case (cfg_addr[2:0])
                    3'd0: sip_v <= cfg_wdata;
                    3'd1: sip_m <= cfg_wdata;
                    3'd2: dip_v <= cfg_wdata;
                    3'd3: dip_m <= cfg_wdata;
                    3'd4: begin sp_v <= cfg_wdata[31:16]; dp_v <= cfg_wdata[15:0]; end
                    3'd5: begin sp_m <= cfg_wdata[31:16]; dp_m <= cfg_wdata[15:0]; end
                    3'd6: begin pr_m <= cfg_wdata[15:8]; pr_v <= cfg_wdata[7:0]; end
                    default: en <= cfg_wdata[0];
                endcase
            end
        end

        assign hit_vec[r] = en &&
            (((key.sip   ^ sip_v) & sip_m) == '0) &&
            (((key.dip   ^ dip_v) & dip_m) == '0) &&
            (((key.sport ^ sp_v)  & sp_m)  == '0) &&
            (((key.dport ^ dp_v)  & dp_m)  == '0) &&
            (((key.proto ^ pr_v)  & pr_m)  == '0);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/ft_commit_fifo.sv
// Byte buffer with a commit pointer. Writes land past the commit point
// and stay invisible to the reader until committed. A rollback discards
// them. The reader drains committed entries one per cycle into a
// registered output.
// Assumes DEPTH is a power of two and the reader is never held off.
module ft_commit_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 9,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         commit,
    input  logic         rollback,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic [PW:0]  commit_ptr,
    output logic [PW:0]  level
);

    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  wr_q, cm_q, rd_q;

    // Storage write, no reset needed on the array.
    always_ff @(posedge clk) begin
        if (wr_en && !rollback) mem[wr_q[PW-1:0]] <= wr_data;
    end

    // Write, commit and read pointer update plus output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0; cm_q <= '0; rd_q <= '0;
            out_valid <= 1'b0; out_data <= '0;
        end else begin
            if (rollback)   wr_q <= cm_q;
            else if (wr_en) wr_q <= wr_q + 1'b1;
            if (commit && !rollback) cm_q <= wr_q + {{PW{1'b0}}, wr_en};
            if (rd_q != cm_q) begin
                out_data  <= mem[rd_q[PW-1:0]];
                rd_q      <= rd_q + 1'b1;
                out_valid <= 1'b1;
            end else begin
                out_valid <= 1'b0;
            end
        end
    end

    assign commit_ptr = cm_q;
    assign level      = wr_q - rd_q;

endmodule

// File: rtl/ft_snap_filter.sv
// Top of the flow thinner. It selects frames by masked five-field rules,
// cuts accepted frames to the snap length and appends a CRC-32 of the
// whole frame. It also keeps forward, drop and cut counters.
// Assumes four idle input cycles after each tlast and a sink that always
// accepts.
module ft_snap_filter
    import ft_pkg::*;
#(
    parameter int NUM_RULES  = 4,
    parameter int FIFO_DEPTH = 128,
    parameter int ADDR_W     = 8,
    parameter int LEN_W      = 16,
    parameter int SNAP_RESET = 64,
    localparam int PW        = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_axis_tvalid,
    input  logic [7:0]        s_axis_tdata,
    input  logic              s_axis_tlast,
    output logic              m_axis_tvalid,
    output logic [7:0]        m_axis_tdata,
    output logic              m_axis_tlast,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata
);

    logic [LEN_W-1:0] idx, snap_q;
    ft_key_t          key;
    logic             key_end, hit, decide, decided_q, keep_q, final_keep;
    logic             in_snap, wr_data_en, fifo_wr, commit, rollback, tail_busy;
    logic [8:0]       fifo_din, fifo_dout;
    logic [2:0]       tail_cnt;
    logic [31:0]      crc_q, crc_nxt, crc_hold;
    logic [31:0]      cnt_match, cnt_drop, cnt_cut;
    logic [PW:0]      commit_ptr, fifo_level;

    ft_hdr_parse #(.LEN_W(LEN_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .in_valid(s_axis_tvalid), .in_data(s_axis_tdata),
        .in_last(s_axis_tlast), .idx_o(idx), .key_o(key), .key_end_o(key_end)
    );

    ft_rule_bank #(.NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W)) u_rules (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .key(key), .hit(hit)
    );

    assign decide     = key_end && !decided_q;
    assign final_keep = decided_q ? keep_q : hit;
    assign in_snap    = idx < snap_q;
    assign tail_busy  = tail_cnt != 3'd0;
    assign crc_nxt    = crc32_step(crc_q, s_axis_tdata);

    assign wr_data_en = s_axis_tvalid && in_snap &&
                        !(decide && !hit) && !(decided_q && !keep_q);
    assign fifo_wr    = wr_data_en || tail_busy;
    assign fifo_din   = tail_busy ? {tail_cnt == 3'd1, crc_hold[7:0]} : {1'b0, s_axis_tdata};
    assign commit     = (decide && hit) || (decided_q && keep_q) || tail_busy;
    assign rollback   = decide && !hit;

    ft_commit_fifo #(.DEPTH(FIFO_DEPTH), .W(9)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(fifo_din),
        .commit(commit), .rollback(rollback), .out_valid(m_axis_tvalid),
        .out_data(fifo_dout), .commit_ptr(commit_ptr), .level(fifo_level)
    );

    assign m_axis_tdata = fifo_dout[7:0];
    assign m_axis_tlast = fifo_dout[8] && m_axis_tvalid;

    // Per-frame verdict, running digest and the trailing digest sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decided_q <= 1'b0; keep_q <= 1'b0; crc_q <= '1;
            crc_hold <= '0; tail_cnt <= '0;
        end else begin
            if (tail_busy) begin
                tail_cnt <= tail_cnt - 3'd1;
                crc_hold <= crc_hold >> 8;
            end
            if (s_axis_tvalid) begin
                if (s_axis_tlast) begin
                    decided_q <= 1'b0;
                    keep_q    <= 1'b0;
                    crc_q     <= '1;
                    if (final_keep) begin
                        crc_hold <= ~crc_nxt;
                        tail_cnt <= 3'd4;
                    end
                end else begin
                    crc_q <= crc_nxt;
                    if (decide) begin
                        decided_q <= 1'b1;
                        keep_q    <= hit;
                    end
                end
            end
        end
    end

    // Snap length register and event counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= LEN_W'(SNAP_RESET);
            cnt_match <= '0; cnt_drop <= '0; cnt_cut <= '0;
        end else begin
            if (cfg_we && cfg_addr == ADDR_W'(REG_SNAP)) snap_q <= cfg_wdata[LEN_W-1:0];
            if (decide && hit)  cnt_match <= cnt_match + 32'd1;
            if (decide && !hit) cnt_drop  <= cnt_drop + 32'd1;
            if (s_axis_tvalid && s_axis_tlast && final_keep && !in_snap)
                cnt_cut <= cnt_cut + 32'd1;
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (cfg_addr)
            ADDR_W'(REG_SNAP):     cfg_rdata = 32'(snap_q);
            ADDR_W'(REG_CNT_HIT):  cfg_rdata = cnt_match;
            ADDR_W'(REG_CNT_DROP): cfg_rdata = cnt_drop;
            ADDR_W'(REG_CNT_CUT):  cfg_rdata = cnt_cut;
            default:               cfg_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/ft_snap_filter_chk.sv
// Property checker for ft_snap_filter, attached with bind below.
// Assumes the input-gap and always-ready sink conditions of the brief.
module ft_snap_filter_chk #(
    parameter int FIFO_DEPTH = 128,
    localparam int PW        = $clog2(FIFO_DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        s_valid,
    input logic        m_valid,
    input logic        m_last,
    input logic        decide,
    input logic        hit,
    input logic        tail_busy,
    input logic [PW:0] commit_ptr,
    input logic [PW:0] fifo_level,
    input logic [31:0] cnt_match
);

    // R9: output is quiet on the first cycle out of reset.
    a_r9_quiet_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !m_valid);

    // R5: tlast only travels with a valid byte.
    a_r5_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid);

    // R2: a drop verdict leaves nothing of the frame committed.
    a_r2_drop_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !hit) |=> $stable(commit_ptr));

    // R10: digest bytes are written only while the input is idle.
    a_r10_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
        tail_busy |-> !s_valid);

    // R10: the buffer never fills under the stated input conditions.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level < (PW+1)'(FIFO_DEPTH));

    // R8: the forward counter steps by at most one per cycle.
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_match == $past(cnt_match)) || (cnt_match == $past(cnt_match) + 32'd1));

endmodule

bind ft_snap_filter ft_snap_filter_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_axis_tvalid), .m_valid(m_axis_tvalid),
    .m_last(m_axis_tlast), .decide(decide), .hit(hit), .tail_busy(tail_busy),
    .commit_ptr(commit_ptr), .fifo_level(fifo_level), .cnt_match(cnt_match)
);

// File: tb/sim_ft_snap_filter.sv
module sim_ft_snap_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_last = 1'b0;
    logic [7:0]  s_data = 8'h0;
    logic        m_valid, m_last;
    logic [7:0]  m_data;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h0;
    logic [31:0] cfg_wdata = 32'h0, cfg_rdata;

    int checks = 0, fails = 0, cyc = 0;
    int expm = 0, expd = 0, expt = 0, snap = 64;
    logic [7:0] pkt [256];
    logic [8:0] got [$];
    logic [8:0] exq [$];

    always #10 clk = ~clk;   // 50 MHz

    ft_snap_filter u0 (
        .clk(clk), .rst_n(rst_n), .s_axis_tvalid(s_valid), .s_axis_tdata(s_data),
        .s_axis_tlast(s_last), .m_axis_tvalid(m_valid), .m_axis_tdata(m_data),
        .m_axis_tlast(m_last), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // Table fields: etype, ihl, proto, sip, dip, sport, dport, len, keep.
    localparam int NV = 12;
    localparam logic [140:0] VEC [NV] = '{
        {16'h0800, 4'd5, 8'd6,  32'hC0A80909, 32'h0A000002, 16'd1234, 16'd80,   16'd64,  1'b1},
        {16'h0800, 4'd5, 8'd6,  32'hC0A80909, 32'h0A000002, 16'd1234, 16'd81,   16'd64,  1'b0},
        {16'h0800, 4'd5, 8'd17, 32'hC0A8014D, 32'h08080808, 16'd5000, 16'd6000, 16'd60,  1'b1},
        {16'h0800, 4'd5, 8'd17, 32'hC0A8024D, 32'h08080808, 16'd5000, 16'd6000, 16'd60,  1'b0},
        {16'h0800, 4'd5, 8'd17, 32'h0A0A0A0A, 32'h0A0A0A0B, 16'd53,   16'd999,  16'd100, 1'b1},
        {16'h0800, 4'd5, 8'd6,  32'h0A0A0A0A, 32'h0A0A0A0B, 16'd53,   16'd999,  16'd100, 1'b0},
        {16'h0800, 4'd7, 8'd6,  32'h0B000001, 32'h0A000002, 16'd4444, 16'd80,   16'd80,  1'b1},
        {16'h0800, 4'd7, 8'd6,  32'h0B000001, 32'h0A000002, 16'd80,   16'd4444, 16'd80,  1'b0},
        {16'h0800, 4'd5, 8'd1,  32'hAC100001, 32'h01020304, 16'd80,   16'd80,   16'd64,  1'b1},
        {16'h0800, 4'd5, 8'd6,  32'hAC100001, 32'h01020304, 16'd80,   16'd80,   16'd64,  1'b0},
        {16'h86DD, 4'd5, 8'd6,  32'hAC100001, 32'h01020304, 16'd80,   16'd0,    16'd64,  1'b0},
        {16'h0800, 4'd5, 8'd6,  32'hC0A80909, 32'h0A000002, 16'd1,    16'd80,   16'd42,  1'b1}
    };

    // Collect output beats away from the active edge.
    always @(negedge clk) if (rst_n && m_valid) got.push_back({m_last, m_data});

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL R10 watchdog: actual %0d cycles, expected completion earlier", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] ref_crc(input int len);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ pkt[i][b];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); cfg_addr = 8'(a); #1 d = cfg_rdata;
    endtask

    task automatic build(input logic [15:0] et, input logic [3:0] ihl, input logic [7:0] pr,
                         input logic [31:0] sip, input logic [31:0] dip,
                         input logic [15:0] sp, input logic [15:0] dp, input int len);
        int l4;
        for (int i = 0; i < len; i++) pkt[i] = 8'(i * 7 + 3);
        pkt[12] = et[15:8]; pkt[13] = et[7:0];
        if (et == 16'h0800) begin
            pkt[14] = {4'h4, ihl};
            pkt[23] = pr;
            for (int k = 0; k < 4; k++) begin
                pkt[26+k] = sip[31-8*k -: 8];
                pkt[30+k] = dip[31-8*k -: 8];
            end
            l4 = 14 + 4 * int'(ihl);
            pkt[l4] = sp[15:8]; pkt[l4+1] = sp[7:0];
            pkt[l4+2] = dp[15:8]; pkt[l4+3] = dp[7:0];
        end
    endtask

    // Append one frame's expected output and bump the counter model.
    task automatic add_exp(input int len, input bit keep);
        logic [31:0] c;
        int n;
        if (keep) begin
            n = (len < snap) ? len : snap;
            for (int i = 0; i < n; i++) exq.push_back({1'b0, pkt[i]});
            c = ref_crc(len);
            exq.push_back({1'b0, c[7:0]});   exq.push_back({1'b0, c[15:8]});
            exq.push_back({1'b0, c[23:16]}); exq.push_back({1'b1, c[31:24]});
            expm++;
            if (len > snap) expt++;
        end else begin
            expd++;
        end
    endtask

    task automatic send(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk); s_valid = 1'b1; s_data = pkt[i]; s_last = (i == len - 1);
        end
        @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input string req, input string what);
        int bad = -1;
        repeat (200) @(negedge clk);
        for (int i = 0; i < exq.size() && i < got.size(); i++)
            if (bad < 0 && got[i] !== exq[i]) bad = i;
        if (got.size() != exq.size())
            check(1'b0, req, {what, " beat count"}, 64'(got.size()), 64'(exq.size()));
        else if (bad >= 0)
            check(1'b0, req, {what, " beat"}, 64'(got[bad]), 64'(exq[bad]));
        else
            check(1'b1, req, what, 0, 0);
        got.delete(); exq.delete();
    endtask

    function automatic string vec_req(input int k);
        case (k)
            6, 7:     return "R7";
            8, 9, 10: return "R6";
            11:       return "R4";
            default:  return VEC[k][0] ? "R1" : "R2";
        endcase
    endfunction

    initial begin
        logic [31:0] v;
        logic [140:0] e;
        repeat (5) @(negedge clk);
        check(m_valid === 1'b0, "R9", "output idle in reset", 64'(m_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(m_valid === 1'b0, "R9", "output idle after reset", 64'(m_valid), 0);
        rd(0, v); check(v == 32'd64, "R9", "snap reset value", 64'(v), 64);
        rd(1, v); check(v == 0, "R9", "forward counter reset", 64'(v), 0);

        // Rules: r0 dst host + TCP + dport 80; r1 source /24; r2 UDP sport 53;
        // r3 source host with dport zero, protocol wildcarded.
        wr(18, 32'h0A000002); wr(19, 32'hFFFFFFFF); wr(20, {16'd0, 16'd80});
        wr(21, {16'h0, 16'hFFFF}); wr(22, {16'h0, 8'hFF, 8'd6}); wr(23, 1);
        wr(24, 32'hC0A80100); wr(25, 32'hFFFFFF00); wr(31, 1);
        wr(36, {16'd53, 16'd0}); wr(37, {16'hFFFF, 16'h0}); wr(38, {16'h0, 8'hFF, 8'd17}); wr(39, 1);
        wr(40, 32'hAC100001); wr(41, 32'hFFFFFFFF); wr(45, {16'h0, 16'hFFFF}); wr(47, 1);
        wr(0, 48); snap = 48;

        for (int k = 0; k < NV; k++) begin
            e = VEC[k];
            build(e[140:125], e[124:121], e[120:113], e[112:81], e[80:49],
                  e[48:33], e[32:17], int'(e[16:1]));
            add_exp(int'(e[16:1]), e[0]);
            send(int'(e[16:1]));
            compare(vec_req(k), $sformatf("table entry %0d", k));
        end

        // R3: disabled all-wildcard rule must not forward; enabled it must.
        wr(47, 0); wr(41, 0); wr(45, 0);
        for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
        add_exp(9, 1'b0); send(9); compare("R3", "disabled rule ignored");
        wr(47, 1);
        for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
        check(ref_crc(9) == 32'hCBF43926, "R5", "digest check value", 64'(ref_crc(9)), 64'hCBF43926);
        add_exp(9, 1'b1); send(9); compare("R5", "short frame digest");

        // R4: new snap length takes effect.
        wr(0, 20); snap = 20;
        e = VEC[0];
        build(e[140:125], e[124:121], e[120:113], e[112:81], e[80:49], e[48:33], e[32:17], 64);
        add_exp(64, 1'b1); send(64); compare("R4", "snap 20");

        // R10: three minimum frames with four idle cycles between.
        e = VEC[2];
        build(e[140:125], e[124:121], e[120:113], e[112:81], e[80:49], e[48:33], e[32:17], 60);
        for (int r = 0; r < 3; r++) add_exp(60, 1'b1);
        for (int r = 0; r < 3; r++) send(60);
        compare("R10", "back-to-back frames");

        // R8: counters against the model.
        rd(1, v); check(v == 32'(expm), "R8", "forward count", 64'(v), 64'(expm));
        rd(2, v); check(v == 32'(expd), "R8", "drop count", 64'(v), 64'(expd));
        rd(3, v); check(v == 32'(expt), "R8", "cut count", 64'(v), 64'(expt));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule